// File: doc/BRIEF.md
# Packed SIMD Lane ALU with Operand Selection

The block is a 64-bit packed-integer ALU. It treats each operand as either eight signed bytes or four signed halfwords. A 5-bit select field sets the lane width. The same field also chooses the second operand from three sources: the whole `vt` vector lane by lane, one element of `vt` copied to every lane, or a 5-bit immediate taken from the low bits of `vt` and copied to every lane.

The operations are:
- saturating add and saturating multiply;
- wrapping subtract;
- bitwise AND, OR, XOR and NOR;
- signed minimum and maximum;
- left, logical-right and arithmetic-right shifts;
- signed compares that write one condition-code bit per lane;
- per-lane picks steered by those condition-code bits.

A condition-code byte enters with each operation. An updated copy leaves with the result. This lets a compare feed a later pick.

Operations enter on a valid/ready stream and results leave on a second valid/ready stream. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is registered at that edge and is presented with `out_valid` from the next cycle. `in_ready` is high when the output register is empty or is being drained in the same cycle (`out_ready` high). The result stays stable until the consumer takes it. The register file that supplies the operands is outside the block.

Top module: `simd_lane_alu`

## Requirements
- R1: The lane format comes from `in_sel`.
  - `in_sel[0]`=0 selects eight bytes.
  - `in_sel[1:0]`=01 selects four halfwords.
  - `in_sel[1:0]`=11 (that is, `in_sel[2:0]` of 011 or 111) is illegal. The result then has `out_illegal`=1, `out_vd`=0 and `out_cc` equal to the incoming `in_cc`.
- R2: Lane 0 is the most significant element. Byte lane i is bits [8*(7-i)+7 : 8*(7-i)]. Halfword lane i is bits [16*(3-i)+15 : 16*(3-i)].
- R3: The second operand is chosen as follows.
  - `in_sel[4]`=0: element `in_sel[3:1]` (bytes) or `in_sel[3:2]` (halfwords) of `in_vt` is broadcast to every lane.
  - `in_sel[4]`=1 and `in_sel[3]`=0: `in_vt` is used lane by lane.
  - `in_sel[4]`=1 and `in_sel[3]`=1: `in_vt[4:0]`, zero-extended, is broadcast to every lane.
- R4: Add (op 0) and multiply (op 2) are signed and saturate to the lane range: 0x7F/0x80 for bytes, 0x7FFF/0x8000 for halfwords.
- R5: Subtract (op 1) and the bitwise operations wrap modulo the lane width. The bitwise codes are AND (op 3), OR (op 4), XOR (op 5) and NOR (op 6).
- R6: Minimum (op 7) and maximum (op 8) compare as signed values.
- R7: Shifts use the low 3 bits (bytes) or low 4 bits (halfwords) of the second operand as the amount. The shift codes are left (op 9), logical right with zero fill (op 10) and arithmetic right with sign fill (op 11).
- R8: The signed compares are equal (op 12), less-than (op 13) and less-or-equal (op 14).
  - The result for lane i is written to `out_cc[i]`, and `out_vd` is 0.
  - In halfword format, `out_cc[7:4]` keeps `in_cc[7:4]`.
  - Every operation that is not a compare passes `in_cc` through unchanged.
- R9: Pick-false (op 15) takes lane i from `in_vs` when `in_cc[i]`=0, otherwise from the selected operand. Pick-true (op 16) does the reverse.
- R10: The result appears with `out_valid` on the cycle after acceptance. `in_ready` = !`out_valid` | `out_ready`. While `out_valid`=1 and `out_ready`=0, the outputs hold stable. After reset, `out_valid` is 0.
- R11: Op codes 17 to 31 produce `out_vd`=0 and pass `in_cc` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 5 | Operation code |
| in_sel | input | 5 | Format and operand select field |
| in_vs | input | 64 | First operand vector |
| in_vt | input | 64 | Second operand vector or immediate source |
| in_cc | input | 8 | Incoming condition-code bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vd | output | 64 | Result vector |
| out_cc | output | 8 | Updated condition-code bits |
| out_illegal | output | 1 | Illegal lane format flag |

## Verification
The assertions assume the following about the environment:
- Reset is asserted before any traffic is offered.
- The inputs are stable whenever `in_valid` is high on an accepting edge.
- The consumer eventually raises `out_ready`.

The bench drives all inputs on the falling edge and holds them across the accepting rising edge, so the operands and `in_cc` captured with `$past` are the ones that were registered. The random stimulus draws the select field from its full 5-bit range, so illegal formats, broadcasts and immediates all occur. One directed stall keeps `out_ready` low for several cycles while a second operation waits.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_SUB   = 5'd1,
    OP_MUL   = 5'd2,
    OP_AND   = 5'd3,
    OP_OR    = 5'd4,
    OP_XOR   = 5'd5,
    OP_NOR   = 5'd6,
    OP_MIN   = 5'd7,
    OP_MAX   = 5'd8,
    OP_SLL   = 5'd9,
    OP_SRL   = 5'd10,
    OP_SRA   = 5'd11,
    OP_CEQ   = 5'd12,
    OP_CLT   = 5'd13,
    OP_CLE   = 5'd14,
    OP_PICKF = 5'd15,
    OP_PICKT = 5'd16
  } alu_op_e;

  function automatic logic op_is_cmp(input logic [4:0] op);
    return (op == OP_CEQ) || (op == OP_CLT) || (op == OP_CLE);
  endfunction
endpackage

// File: rtl/simd_opnd_sel.sv
module simd_opnd_sel #(
  parameter int DATA_W = 64
) (
  input  logic [4:0]        sel,
  input  logic [DATA_W-1:0] vt,
  output logic [DATA_W-1:0] opnd_byte,
  output logic [DATA_W-1:0] opnd_half,
  output logic              fmt_half,
  output logic              fmt_bad
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  logic [7:0]  vt_b [NB];
  logic [15:0] vt_h [NH];
  logic [7:0]  bcast_b;
  logic [15:0] bcast_h;

  // lane 0 lives in the most significant slot (R2)
  for (genvar i = 0; i < NB; i++) begin : g_split_b
    assign vt_b[i] = vt[8*(NB-1-i) +: 8];
  end
  for (genvar i = 0; i < NH; i++) begin : g_split_h
    assign vt_h[i] = vt[16*(NH-1-i) +: 16];
  end

  // R3: element broadcast index vs immediate
  always_comb begin
    if (!sel[4]) begin
      bcast_b = vt_b[sel[3:1]];
      bcast_h = vt_h[sel[3:2]];
    end else begin
      bcast_b = {3'b000, vt[4:0]};
      bcast_h = {11'd0, vt[4:0]};
    end
  end

  wire use_vec = sel[4] & ~sel[3];

  for (genvar i = 0; i < NB; i++) begin : g_out_b
    assign opnd_byte[8*(NB-1-i) +: 8] = use_vec ? vt_b[i] : bcast_b;
  end
  for (genvar i = 0; i < NH; i++) begin : g_out_h
    assign opnd_half[16*(NH-1-i) +: 16] = use_vec ? vt_h[i] : bcast_h;
  end

  assign fmt_half = sel[0] & ~sel[1];
  assign fmt_bad  = sel[0] & sel[1];

  always_comb begin
    assert_fmt_exclusive_R1: assert (!(fmt_half && fmt_bad));
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cc_bit,
  output logic [W-1:0] res,
  output logic         cmp
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  logic signed [W:0]     sum;
  logic signed [2*W-1:0] prod;
  logic [W-1:0]          sum_sat, prod_sat, mn_v, mx_v;
  logic signed [W-1:0]   sra_v;
  logic [SW-1:0]         sh;
  logic                  eq, lt;

  assign sum  = $signed({a[W-1], a}) + $signed({b[W-1], b});
  assign prod = $signed(a) * $signed(b);
  assign sh   = b[SW-1:0];
  assign eq   = (a == b);
  assign lt   = $signed(a) < $signed(b);

  // R4: clamp when the top bits disagree
  assign sum_sat  = (sum[W] != sum[W-1]) ? (sum[W] ? SMIN : SMAX) : sum[W-1:0];
  assign prod_sat = (prod[2*W-1:W-1] != {(W+1){1'b0}} && prod[2*W-1:W-1] != {(W+1){1'b1}})
                    ? (prod[2*W-1] ? SMIN : SMAX) : prod[W-1:0];
  assign mn_v  = lt ? a : b;
  assign mx_v  = lt ? b : a;
  assign sra_v = $signed(a) >>> sh;

  always_comb begin
    res = '0;
    cmp = 1'b0;
    case (opc)
      OP_ADD:   res = sum_sat;
      OP_SUB:   res = a - b;
      OP_MUL:   res = prod_sat;
      OP_AND:   res = a & b;
      OP_OR:    res = a | b;
      OP_XOR:   res = a ^ b;
      OP_NOR:   res = ~(a | b);
      OP_MIN:   res = mn_v;
      OP_MAX:   res = mx_v;
      OP_SLL:   res = a << sh;
      OP_SRL:   res = a >> sh;
      OP_SRA:   res = sra_v;
      OP_CEQ:   cmp = eq;
      OP_CLT:   cmp = lt;
      OP_CLE:   cmp = lt | eq;
      OP_PICKF: res = cc_bit ? b : a;
      OP_PICKT: res = cc_bit ? a : b;
      default:  res = '0;
    endcase
  end

  always_comb begin
    assert_cmp_exclusive_R8: assert (!(eq && lt));
    assert_minmax_order_R6: assert ($signed(mn_v) <= $signed(mx_v));
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [4:0]        in_sel,
  input  logic [DATA_W-1:0] in_vs,
  input  logic [DATA_W-1:0] in_vt,
  input  logic [DATA_W/8-1:0] in_cc,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_vd,
  output logic [DATA_W/8-1:0] out_cc,
  output logic              out_illegal
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;

  logic [DATA_W-1:0] opnd_byte, opnd_half, res_b, res_h, nxt_vd;
  logic [NB-1:0]     cmp_b, nxt_cc;
  logic [NH-1:0]     cmp_h;
  logic              fmt_half, fmt_bad, is_cmp, accept;

  simd_opnd_sel #(.DATA_W(DATA_W)) u_sel (
    .sel(in_sel), .vt(in_vt),
    .opnd_byte(opnd_byte), .opnd_half(opnd_half),
    .fmt_half(fmt_half), .fmt_bad(fmt_bad)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_lane #(.W(8)) u_lane (
      .op(in_op), .a(in_vs[8*(NB-1-i) +: 8]), .b(opnd_byte[8*(NB-1-i) +: 8]),
      .cc_bit(in_cc[i]), .res(res_b[8*(NB-1-i) +: 8]), .cmp(cmp_b[i])
    );
  end
  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_lane #(.W(16)) u_lane (
      .op(in_op), .a(in_vs[16*(NH-1-i) +: 16]), .b(opnd_half[16*(NH-1-i) +: 16]),
      .cc_bit(in_cc[i]), .res(res_h[16*(NH-1-i) +: 16]), .cmp(cmp_h[i])
    );
  end

  assign is_cmp = op_is_cmp(in_op);

  always_comb begin
    nxt_vd = fmt_bad ? '0 : (fmt_half ? res_h : res_b);
    nxt_cc = in_cc;
    if (is_cmp && !fmt_bad) begin
      if (fmt_half) nxt_cc[NH-1:0] = cmp_h;
      else          nxt_cc = cmp_b;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_vd      <= '0;
      out_cc      <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_vd      <= nxt_vd;
      out_cc      <= nxt_cc;
      out_illegal <= fmt_bad;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vd) && $stable(out_cc)));
  assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sel[1:0] == 2'b11) |=> (out_illegal && out_vd == '0 && out_cc == $past(in_cc)));
  assert_cc_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_cmp) |=> (out_cc == $past(in_cc)));
  assert_cc_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_sel[1:0] == 2'b01) |=> (out_cc[NB-1:NH] == $past(in_cc[NB-1:NH])));
endmodule

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_ready, out_valid, out_ready = 1, out_illegal;
  logic [4:0]  in_op = 0, in_sel = 0;
  logic [63:0] in_vs = 0, in_vt = 0, out_vd;
  logic [7:0]  in_cc = 0, out_cc;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_lane_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sel(in_sel), .in_vs(in_vs), .in_vt(in_vt), .in_cc(in_cc),
    .out_valid(out_valid), .out_ready(out_ready), .out_vd(out_vd),
    .out_cc(out_cc), .out_illegal(out_illegal)
  );

  function automatic longint lane_of(input logic [63:0] v, input int w, input int n, input int idx);
    longint x, lim;
    lim = longint'(1) <<< (w - 1);
    x = longint'((v >> (w * (n - 1 - idx))) & ((64'd1 << w) - 64'd1));
    if (x >= lim) x = x - 2 * lim;
    return x;
  endfunction

  function automatic logic [72:0] model(input logic [4:0] op, input logic [4:0] sel,
                                        input logic [63:0] vs, input logic [63:0] vt,
                                        input logic [7:0] cc);
    int w, n, sh;
    longint a, b, r, lim;
    logic [63:0] vd, m;
    logic [7:0] nc;
    if (sel[0] && sel[1]) return {1'b1, cc, 64'd0};
    w = sel[0] ? 16 : 8;
    n = 64 / w;
    lim = longint'(1) <<< (w - 1);
    m = (64'd1 << w) - 64'd1;
    vd = 0;
    nc = cc;
    for (int i = 0; i < n; i++) begin
      a = lane_of(vs, w, n, i);
      if (!sel[4]) b = lane_of(vt, w, n, (w == 8) ? int'(sel[3:1]) : int'(sel[3:2]));
      else if (sel[3]) b = longint'(vt[4:0]);
      else b = lane_of(vt, w, n, i);
      sh = int'(b & ((w == 8) ? 7 : 15));
      r = 0;
      case (op)
        0: r = a + b;
        1: r = a - b;
        2: r = a * b;
        3: r = a & b;
        4: r = a | b;
        5: r = a ^ b;
        6: r = ~(a | b);
        7: r = (a < b) ? a : b;
        8: r = (a < b) ? b : a;
        9: r = a << sh;
        10: r = longint'(64'(a) & m) >> sh;
        11: r = a >>> sh;
        12: nc[i] = (a == b);
        13: nc[i] = (a < b);
        14: nc[i] = (a <= b);
        15: r = cc[i] ? b : a;
        16: r = cc[i] ? a : b;
        default: r = 0;
      endcase
      if (op == 0 || op == 2) begin
        if (r > lim - 1) r = lim - 1;
        if (r < -lim) r = -lim;
      end
      vd = vd | ((64'(r) & m) << (w * (n - 1 - i)));
    end
    return {1'b0, nc, vd};
  endfunction

  function automatic string tag_of(input logic [4:0] op, input logic [4:0] sel);
    if (sel[0] && sel[1]) return "R1";
    if (op == 0 || op == 2) return "R4";
    if (op == 1 || (op >= 3 && op <= 6)) return "R5";
    if (op == 7 || op == 8) return "R6";
    if (op >= 9 && op <= 11) return "R7";
    if (op >= 12 && op <= 14) return "R8";
    if (op == 15 || op == 16) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input logic [72:0] got, input logic [72:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual ill=%0b cc=%h vd=%h expected ill=%0b cc=%h vd=%h",
               tag, got[72], got[71:64], got[63:0], exp[72], exp[71:64], exp[63:0]);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [4:0] sel, input logic [63:0] vs,
                        input logic [63:0] vt, input logic [7:0] cc, input string tag,
                        input bit use_lit, input logic [72:0] lit);
    logic [72:0] exp;
    @(negedge clk);
    in_op = op; in_sel = sel; in_vs = vs; in_vt = vt; in_cc = cc;
    in_valid = 1; out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check_bit({tag, " R10 valid after accept"}, out_valid, 1'b1);
    exp = use_lit ? lit : model(op, sel, vs, vt, cc);
    check(tag, {out_illegal, out_cc, out_vd}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [72:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_bit("R10 reset out_valid", out_valid, 1'b0);
    check_bit("R10 reset in_ready", in_ready, 1'b1);

    // R4 saturation at both ends, bytes, vector operand
    run_op(5'd0, 5'b10110, 64'h7F80_0102_0304_0506, 64'h0180_0101_0101_0101, 8'h3C,
           "R4 add sat bytes", 1, {1'b0, 8'h3C, 64'h7F80_0203_0405_0607});
    run_op(5'd2, 5'b10101, 64'h4000_8000_0003_FFFF, 64'h0004_8000_0005_0002, 8'h00,
           "R4 mul sat halves", 1, {1'b0, 8'h00, 64'h7FFF_7FFF_000F_FFFE});
    // R1 illegal formats
    run_op(5'd0, 5'b00011, 64'h1234, 64'h5678, 8'hA5,
           "R1 illegal 011", 1, {1'b1, 8'hA5, 64'h0});
    run_op(5'd12, 5'b11111, 64'h1234, 64'h1234, 8'h5A,
           "R1 illegal 111", 1, {1'b1, 8'h5A, 64'h0});
    // R3 immediate broadcast from low five bits only
    run_op(5'd4, 5'b11110, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00,
           "R3 immediate", 1, {1'b0, 8'h00, 64'h1F1F_1F1F_1F1F_1F1F});
    // R2 element 0 is the most significant byte, element 7 the least
    run_op(5'd4, 5'b00000, 64'h0, 64'h1122_3344_5566_7788, 8'h00,
           "R2 elem0", 1, {1'b0, 8'h00, 64'h1111_1111_1111_1111});
    run_op(5'd4, 5'b01110, 64'h0, 64'h1122_3344_5566_7788, 8'h00,
           "R2 elem7", 1, {1'b0, 8'h00, 64'h8888_8888_8888_8888});
    run_op(5'd4, 5'b00101, 64'h0, 64'h1111_2222_3333_4444, 8'h00,
           "R3 half elem1", 1, {1'b0, 8'h00, 64'h2222_2222_2222_2222});
    // R7 shift amount masked: imm 9 -> 1 for bytes
    run_op(5'd10, 5'b11110, 64'h8080_8080_8080_8080, 64'd9, 8'h00,
           "R7 srl", 1, {1'b0, 8'h00, 64'h4040_4040_4040_4040});
    run_op(5'd11, 5'b11110, 64'h8080_8080_8080_8080, 64'd9, 8'h00,
           "R7 sra", 1, {1'b0, 8'h00, 64'hC0C0_C0C0_C0C0_C0C0});
    // R8 halfword compare keeps upper cc bits
    run_op(5'd13, 5'b10101, 64'h8000_0001_0005_7FFF, 64'h0000_0001_0004_8000, 8'hF0,
           "R8 clt halves", 1, {1'b0, 8'hF1, 64'h0});
    // R9 pick-false
    run_op(5'd15, 5'b10110, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 8'h0F,
           "R9 pickf", 1, {1'b0, 8'h0F, 64'h5555_5555_AAAA_AAAA});
    // R5 wrap subtract and R6 signed min
    run_op(5'd1, 5'b10110, 64'h8000_0000_0000_0000, 64'h0100_0000_0000_0000, 8'h00,
           "R5 sub wrap", 1, {1'b0, 8'h00, 64'h7F00_0000_0000_0000});
    run_op(5'd7, 5'b10110, 64'h80FF_0000_0000_0000, 64'h7F01_0000_0000_0000, 8'h00,
           "R6 min signed", 1, {1'b0, 8'h00, 64'h80FF_0000_0000_0000});
    // R11 unused code
    run_op(5'd20, 5'b10110, 64'hFFFF, 64'hFFFF, 8'h77,
           "R11 unused", 1, {1'b0, 8'h77, 64'h0});

    // R10 back-pressure: result holds and input waits while stalled
    @(negedge clk);
    in_op = 5'd4; in_sel = 5'b10110; in_vs = 64'h00FF; in_vt = 64'hFF00; in_cc = 8'h00;
    in_valid = 1; out_ready = 0;
    @(posedge clk);
    @(negedge clk);
    held = {out_illegal, out_cc, out_vd};
    in_vs = 64'h1; in_vt = 64'h2;
    repeat (3) @(negedge clk);
    check_bit("R10 in_ready low while stalled", in_ready, 1'b0);
    check("R10 hold", {out_illegal, out_cc, out_vd}, {1'b0, 8'h00, 64'hFFFF});
    check("R10 hold stable", {out_illegal, out_cc, out_vd}, held);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check("R10 next after drain", {out_illegal, out_cc, out_vd}, {1'b0, 8'h00, 64'h3});
    @(negedge clk);
    check_bit("R10 drained", out_valid, 1'b0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [4:0] op, sel;
      op  = 5'($urandom_range(0, 18));
      sel = 5'($urandom_range(0, 31));
      run_op(op, sel, {$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom),
             tag_of(op, sel), 0, 73'd0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule